// File: doc/BRIEF.md
# Indexed Colour Palette Lookup

This block turns pixel data into 8-bit-per-channel RGB for a display controller. It keeps a 256-entry table of 16-bit colours. The table is stored as 128 words of 32 bits, so each word holds a pair of entries. A CPU port writes one whole word per cycle, addressed by word number. A pixel port presents one pixel per cycle with a valid strobe. One clock later it returns the widened colour, an intensity flag and a matching valid strobe.

A per-pixel depth select chooses how the pixel is used:

- **8 bpp:** the low byte indexes the table.
- **16 bpp:** the 16-bit value is decoded directly, without the table.
- **24 bpp:** the three bytes pass straight through as colour.

A format input picks how a 16-bit colour is read:

- **1555:** an intensity bit plus three 5-bit channels.
- **565:** 5/6/5 channels.

A swap input exchanges the red and blue outputs. A pair-order input chooses which half of a stored word belongs to the even index.

Top module: `pal_lookup`

## Requirements
- R1: A CPU write with `wr_en` high stores `wr_data` in word `wr_addr`. With `pair_swap` low, index 2k reads bits 15:0 of word k and index 2k+1 reads bits 31:16.
- R2: With format 1555 (`fmt_565`=0), bit 15 of an entry drives `out_int`. Bits 14:10 are blue, bits 9:5 are green and bits 4:0 are red.
- R3: With format 565 (`fmt_565`=1), bits 15:11 are red, bits 10:5 are green and bits 4:0 are blue, and `out_int` is 0.
- R4: A 5-bit channel c widens to {c, c[4:2]} and a 6-bit channel c widens to {c, c[5:4]}.
- R5: With `bpp_sel`=00 the table is used. With `bpp_sel`=01, `pix_data[15:0]` is decoded as an entry by the selected format, without the table. With `bpp_sel`=1x, red is `pix_data[23:16]`, green is `pix_data[15:8]`, blue is `pix_data[7:0]` and `out_int` is 0.
- R6: With `rb_swap`=1, the red and blue outputs are exchanged in every depth mode.
- R7: A pixel accepted with `pix_valid` high appears on the outputs exactly one clock later with `out_valid` high. `out_valid` is low in every other cycle.
- R8: If a word is written in the same cycle that a pixel reads it, the pixel gets the contents from before the write.
- R9: With `pair_swap`=1, index 2k reads bits 31:16 of word k and index 2k+1 reads bits 15:0.
- R10: After reset, `out_valid` is 0 and all colour outputs are 0.
- R11: In a cycle after which no pixel was accepted, the colour and intensity outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU word write strobe |
| wr_addr | input | IDX_W-1 | Word number to write |
| wr_data | input | 32 | Two packed 16-bit entries |
| pix_valid | input | 1 | Pixel input is present |
| pix_data | input | 24 | Index, 16-bit colour or 24-bit colour |
| bpp_sel | input | 2 | 00: 8 bpp, 01: 16 bpp, 1x: 24 bpp |
| fmt_565 | input | 1 | 1: 565 entries, 0: 1555 entries |
| rb_swap | input | 1 | Exchange red and blue |
| pair_swap | input | 1 | Even index takes the upper half-word |
| out_valid | output | 1 | Output colour is valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| out_int | output | 1 | Intensity bit (1555 only) |

## Verification
The bench builds the block with its default `IDX_W` of 8. This gives the full 128-word table, so the first and last words and indices 0 and 255 can all be reached. A same-cycle write and read of one word can also be set up.

The scoreboard works from its own copy of the table. It covers both entry formats, all three depth modes with and without the red/blue swap, and both pair orders. It also runs back-to-back pixels and idle gaps, which test that the outputs hold their values.

// File: rtl/pal_lookup.sv
module pal_lookup #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-2:0] wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             pix_valid,
  input  logic [23:0]      pix_data,
  input  logic [1:0]       bpp_sel,
  input  logic             fmt_565,
  input  logic             rb_swap,
  input  logic             pair_swap,
  output logic             out_valid,
  output logic [7:0]       out_r,
  output logic [7:0]       out_g,
  output logic [7:0]       out_b,
  output logic             out_int
);
  localparam int WORDS = 2 ** (IDX_W - 1);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  wire [31:0] rd_word = mem[pix_data[IDX_W-1:1]];
  wire        hi_half = pix_data[0] ^ pair_swap;
  wire [15:0] pal_ent = hi_half ? rd_word[31:16] : rd_word[15:0];
  wire [15:0] ent     = (bpp_sel == 2'b00) ? pal_ent : pix_data[15:0];

  logic [7:0] r_n, g_n, b_n;
  logic       i_n;

  always_comb begin
    if (bpp_sel[1]) begin
      r_n = pix_data[23:16];
      g_n = pix_data[15:8];
      b_n = pix_data[7:0];
      i_n = 1'b0;
    end else if (fmt_565) begin
      r_n = {ent[15:11], ent[15:13]};
      g_n = {ent[10:5], ent[10:9]};
      b_n = {ent[4:0], ent[4:2]};
      i_n = 1'b0;
    end else begin
      r_n = {ent[4:0], ent[4:2]};
      g_n = {ent[9:5], ent[9:7]};
      b_n = {ent[14:10], ent[14:12]};
      i_n = ent[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
      out_int   <= 1'b0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) begin
        out_r   <= rb_swap ? b_n : r_n;
        out_g   <= g_n;
        out_b   <= rb_swap ? r_n : b_n;
        out_int <= i_n;
      end
    end
  end

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  p_565_no_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt_565) |=> !out_int);
  p_direct_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bpp_sel[1] && !rb_swap) |=>
      (out_r == $past(pix_data[23:16]) && out_b == $past(pix_data[7:0])));
  p_swap_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bpp_sel[1] && rb_swap) |=>
      (out_r == $past(pix_data[7:0]) && out_b == $past(pix_data[23:16])));
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b) && $stable(out_int)));
endmodule

// File: tb/pal_lookup_tb.sv
`timescale 1ns/1ps
module pal_lookup_tb;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic       i;
  } col_t;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [6:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pix_valid = 0;
  logic [23:0] pix_data = '0;
  logic [1:0] bpp_sel = '0;
  logic fmt_565 = 0, rb_swap = 0, pair_swap = 0;
  logic out_valid, out_int;
  logic [7:0] out_r, out_g, out_b;

  int tests = 0, fails = 0;
  logic [31:0] shadow [128];
  col_t exp_q[$];
  string tag_q[$];
  col_t last = '0;
  bit started = 0;

  always #4 clk = ~clk;

  pal_lookup u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_valid(pix_valid), .pix_data(pix_data), .bpp_sel(bpp_sel),
    .fmt_565(fmt_565), .rb_swap(rb_swap), .pair_swap(pair_swap), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_int(out_int));

  function automatic logic [7:0] w5(logic [4:0] c); return {c, c[4:2]}; endfunction
  function automatic logic [7:0] w6(logic [5:0] c); return {c, c[5:4]}; endfunction

  function automatic col_t model(logic [1:0] bpp, logic f, logic sw, logic be, logic [23:0] pd);
    logic [15:0] e;
    logic [31:0] w;
    logic [7:0] t;
    col_t c;
    w = shadow[pd[7:1]];
    e = (bpp == 2'b00) ? ((pd[0] != be) ? w[31:16] : w[15:0]) : pd[15:0];
    if (bpp[1]) begin c.r = pd[23:16]; c.g = pd[15:8]; c.b = pd[7:0]; c.i = 0; end
    else if (f) begin c.r = w5(e[15:11]); c.g = w6(e[10:5]); c.b = w5(e[4:0]); c.i = 0; end
    else begin c.r = w5(e[4:0]); c.g = w5(e[9:5]); c.b = w5(e[14:10]); c.i = e[15]; end
    if (sw) begin t = c.r; c.r = c.b; c.b = t; end
    return c;
  endfunction

  task automatic check(string tag, col_t act, col_t exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got r=%h g=%h b=%h i=%b expected r=%h g=%h b=%h i=%b",
        tag, act.r, act.g, act.b, act.i, exp.r, exp.g, exp.b, exp.i);
    end
  endtask

  task automatic cyc(bit we, logic [6:0] wa, logic [31:0] wd, bit pv, logic [1:0] bpp,
                     logic f, logic sw, logic be, logic [23:0] pd, string tag);
    wr_en = we; wr_addr = wa; wr_data = wd;
    pix_valid = pv; bpp_sel = bpp; fmt_565 = f; rb_swap = sw; pair_swap = be; pix_data = pd;
    if (pv) begin exp_q.push_back(model(bpp, f, sw, be, pd)); tag_q.push_back(tag); end
    if (we) shadow[wa] = wd;
    @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic px(logic [1:0] bpp, logic f, logic sw, logic be, logic [23:0] pd, string tag);
    cyc(0, 0, 0, 1, bpp, f, sw, be, pd, tag);
  endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && started) begin
      if (out_valid) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R7: out_valid=1 expected 0 (no pixel pending)");
        end else begin
          col_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {out_r, out_g, out_b, out_int}, e);
        end
        last = {out_r, out_g, out_b, out_int};
      end else begin
        check("R11 hold", {out_r, out_g, out_b, out_int}, last);
        tests++;
        if (exp_q.size() != 0) begin
          fails++;
          $display("FAIL R7: out_valid=0 expected 1");
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++; tests++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", {out_r, out_g, out_b, out_int}, '0);
    tests++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R10: out_valid=%b expected 0", out_valid); end
    rst_n = 1;
    @(negedge clk);
    started = 1;
    wr(7'd0, 32'h8123_F81F);
    wr(7'd1, 32'h07E0_ABCD);
    wr(7'd64, 32'h7C00_03E0);
    wr(7'd127, 32'hFFFF_8421);
    px(0, 1, 0, 0, 24'd0, "R1 even index low half");
    px(0, 1, 0, 0, 24'd1, "R1 odd index high half");
    px(0, 0, 0, 0, 24'd1, "R2 1555 intensity set");
    px(0, 0, 0, 0, 24'd128, "R2 1555 green");
    px(0, 0, 0, 0, 24'd129, "R2 1555 blue");
    px(0, 1, 0, 0, 24'd2, "R4 565 widen");
    px(0, 1, 0, 0, 24'd255, "R3 565 no intensity idx255");
    px(0, 0, 0, 0, 24'd255, "R2 1555 idx255");
    idle(3);
    px(0, 1, 1, 0, 24'd0, "R6 swap palette 565");
    px(0, 0, 1, 0, 24'd2, "R6 swap palette 1555");
    px(0, 1, 0, 1, 24'd0, "R9 pair swap even");
    px(0, 1, 0, 1, 24'd1, "R9 pair swap odd");
    px(0, 0, 0, 1, 24'd254, "R9 pair swap idx254");
    idle(2);
    cyc(1, 7'd0, 32'h1234_5678, 1, 0, 1, 0, 0, 24'd0, "R8 collision old data");
    shadow[0] = 32'h1234_5678;
    px(0, 1, 0, 0, 24'd0, "R8 new data after write");
    px(1, 1, 0, 0, 24'h00F81F, "R5 16bpp 565");
    px(1, 0, 0, 0, 24'h00FC00, "R5 16bpp 1555");
    px(1, 0, 1, 0, 24'h00801F, "R6 16bpp swap");
    px(2, 0, 0, 0, 24'h123456, "R5 24bpp");
    px(3, 1, 0, 0, 24'hA0B0C0, "R5 24bpp code 11");
    px(2, 0, 1, 0, 24'h123456, "R6 24bpp swap");
    idle(4);
    px(0, 1, 0, 0, 24'd3, "R7 single pixel");
    idle(1);
    px(2, 0, 0, 0, 24'hFEDCBA, "R7 after gap");
    idle(5);
    tests++;
    if (exp_q.size() != 0) begin fails++; $display("FAIL R7: %0d outputs missing expected 0", exp_q.size()); end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule